// File: doc/BRIEF.md
# Modem Line Status and Interrupt Identification Registers

This block is the register slice of a byte-wide serial port that watches the four incoming modem lines (clear-to-send, data-set-ready, ring indicator and carrier detect) and raises one interrupt request. All four lines pass through a synchronizer. A sticky flag records any change of the synchronized carrier-detect level. The block holds an interrupt mask, a modem-control byte that drives the data-terminal-ready and request-to-send outputs, and a control byte whose lowest bit turns on hardware flow control.

Two conditions arrive as plain level flags from the rest of the port: receive data available and transmit buffer empty. They are combined with the carrier-change flag under the mask. A status byte then reports whether a request is pending and which source has priority. Software reaches everything through a small register port with a 4-bit address and 8-bit data. Each strobe is answered by a single-cycle acknowledge one clock later. The master drops the strobe in the acknowledge cycle, so there is no back-pressure beyond that fixed one-cycle latency.

Top module: `modem_irq_regs`

## Requirements
- R1: An access starts in a cycle where `bus_req` is high and `bus_ack` is low. `bus_ack` is high in the following cycle only, and read data is valid on `bus_rdata` in that same cycle.
- R2: A read of offset 2 returns the synchronized levels in bit 4 (CTS), bit 5 (DSR), bit 6 (RI) and bit 7 (DCD), the carrier-change flag in bit 3, and zero in bits 0 to 2. A line change is visible after two clock edges of synchronization.
- R3: A rise or fall of synchronized DCD sets the carrier-change flag. A write of any value to offset 2 clears it. If a new change coincides with the clearing write, the flag stays set.
- R4: Offset 4 is the interrupt mask. Bit 0 enables receive-data, bit 1 enables transmit-empty, and bit 3 enables carrier-change. Only these bits are stored; every other bit reads 0.
- R5: Offset 6 drives `dtr_out` from bit 0 and `rts_out` from bit 1. Both reset to parameter values that default to 1. Other bits read 0.
- R6: Offset 7 bit 0 enables flow control. While it is clear, `tx_may_start` is 1. While it is set, `tx_may_start` follows the synchronized CTS level. Other bits read 0.
- R7: A read of offset 3 returns bit 7 = request pending and bits 4..2 = source code. Bits 0, 1, 5 and 6 read 0, and the code is 000 when nothing is pending.
- R8: Source codes are receive = 001, transmit = 010 and carrier-change = 011. Receive has the highest priority and carrier-change the lowest. A source whose mask bit is clear is ignored.
- R9: `irq` is 1 exactly when at least one enabled source is active, and it equals bit 7 of offset 3.
- R10: Offsets 0, 1, 5 and 8 to 15 read 0, and writes to them change no other register.
- R11: After reset, the mask and control bytes are 0, `irq` is 0 and the carrier-change flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access acknowledge |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| rx_avail | input | 1 | Receive data available flag |
| tx_empty | input | 1 | Transmit buffer empty flag |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| tx_may_start | output | 1 | Transmitter permitted to start a frame |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or lost carrier-change flag appears at the ports as `irq` staying high after the clearing write, or never rising. It also shows in bit 3 of the next offset-2 read, three edges after the line moves. A wrong priority or wrong mask storage shows in the source code on the very next offset-3 read and in `irq` in the same cycle the flags change. A broken synchronizer or flow-control gate shows on `tx_may_start` or in the level bits within a few cycles of a line toggle.

// File: rtl/mi_pkg.sv
package mi_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 3;

  localparam logic [ADDR_W-1:0] OFF_MSR = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_ISR = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_IER = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_MCR = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_CTL = 4'd7;

  localparam logic [DATA_W-1:0] IER_MASK = 8'h0B;
  localparam logic [DATA_W-1:0] MCR_MASK = 8'h03;
  localparam logic [DATA_W-1:0] CTL_MASK = 8'h01;

  localparam int unsigned IER_RX_BIT = 0;
  localparam int unsigned IER_TX_BIT = 1;
  localparam int unsigned IER_MS_BIT = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE  = 3'b000,
    SRC_RX    = 3'b001,
    SRC_TX    = 3'b010,
    SRC_MODEM = 3'b011
  } irq_src_e;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_lines_t;
endpackage

// File: rtl/mi_line_sync.sv
module mi_line_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mi_change_latch.sv
module mi_change_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic clr,
  output logic edge_o,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;

  assign edge_o = level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (edge_o)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mi_irq_encoder.sv
module mi_irq_encoder #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned CODE_W = 3
) (
  input  logic [N_SRC-1:0]  active,
  output logic              pending,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (active[i]) code = CODE_W'(i + 1);
    end
  end

  assign pending = |active;
endmodule

// File: rtl/modem_irq_regs.sv
module modem_irq_regs
  import mi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          DTR_INIT    = 1'b1,
  parameter bit          RTS_INIT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  input  logic              rx_avail,
  input  logic              tx_empty,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              tx_may_start,
  output logic              irq
);
  localparam int unsigned N_LINES = $bits(modem_lines_t);
  localparam int unsigned N_SRC   = 3;

  modem_lines_t          lines_raw;
  modem_lines_t          lines_s;
  logic                  dcd_edge;
  logic                  dcd_chg;
  logic                  access;
  logic                  wr_fire;
  logic                  msr_clr;
  logic [DATA_W-1:0]     ie_q;
  logic [DATA_W-1:0]     mc_q;
  logic [DATA_W-1:0]     ctl_q;
  logic [N_SRC-1:0]      src_active;
  logic                  src_pending;
  logic [CODE_W-1:0]     isr_code;
  logic [DATA_W-1:0]     msr_val;
  logic [DATA_W-1:0]     isr_val;
  logic [DATA_W-1:0]     rd_mux;
  logic                  ack_q;
  logic [DATA_W-1:0]     rdata_q;

  assign lines_raw = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};

  mi_line_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lines_raw),
    .q     (lines_s)
  );

  assign access  = bus_req & ~ack_q;
  assign wr_fire = access & bus_wr;
  assign msr_clr = wr_fire & (bus_addr == OFF_MSR);

  mi_change_latch u_dcd_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (lines_s.dcd),
    .clr    (msr_clr),
    .edge_o (dcd_edge),
    .flag_o (dcd_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      mc_q  <= {{(DATA_W-2){1'b0}}, RTS_INIT, DTR_INIT};
      ctl_q <= '0;
    end else if (wr_fire) begin
      case (bus_addr)
        OFF_IER: ie_q  <= bus_wdata & IER_MASK;
        OFF_MCR: mc_q  <= bus_wdata & MCR_MASK;
        OFF_CTL: ctl_q <= bus_wdata & CTL_MASK;
        default: ;
      endcase
    end
  end

  assign src_active = {ie_q[IER_MS_BIT] & dcd_chg,
                       ie_q[IER_TX_BIT] & tx_empty,
                       ie_q[IER_RX_BIT] & rx_avail};

  mi_irq_encoder #(
    .N_SRC  (N_SRC),
    .CODE_W (CODE_W)
  ) u_enc (
    .active  (src_active),
    .pending (src_pending),
    .code    (isr_code)
  );

  assign msr_val = {lines_s.dcd, lines_s.ri, lines_s.dsr, lines_s.cts, dcd_chg, 3'b000};
  assign isr_val = {src_pending, 2'b00, isr_code, 2'b00};

  always_comb begin
    case (bus_addr)
      OFF_MSR: rd_mux = msr_val;
      OFF_ISR: rd_mux = isr_val;
      OFF_IER: rd_mux = ie_q;
      OFF_MCR: rd_mux = mc_q;
      OFF_CTL: rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= access;
      if (access) rdata_q <= bus_wr ? '0 : rd_mux;
    end
  end

  assign bus_ack      = ack_q;
  assign bus_rdata    = rdata_q;
  assign dtr_out      = mc_q[0];
  assign rts_out      = mc_q[1];
  assign tx_may_start = ~ctl_q[0] | lines_s.cts;
  assign irq          = src_pending;
endmodule

// File: rtl/mi_checker.sv
module mi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_wr,
  input logic [3:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_ack,
  input logic       dtr_out,
  input logic       rts_out,
  input logic       tx_may_start,
  input logic       irq,
  input logic       rx_avail,
  input logic       tx_empty,
  input logic [7:0] ie_q,
  input logic [7:0] ctl_q,
  input logic       cts_s,
  input logic       dcd_edge,
  input logic       dcd_chg,
  input logic [2:0] isr_code
);
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_ack); // R1
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R1
  AST_CHG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dcd_edge |=> dcd_chg); // R3
  AST_CHG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && bus_wr && bus_addr == 4'd2 && !dcd_edge |=> !dcd_chg); // R3
  AST_MC_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && bus_wr && bus_addr == 4'd6
    |=> dtr_out == $past(bus_wdata[0]) && rts_out == $past(bus_wdata[1])); // R5
  AST_FLOW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] && !cts_s |-> !tx_may_start); // R6
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q[0] && rx_avail |-> isr_code == 3'b001); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q[0] && rx_avail) || (ie_q[1] && tx_empty) || (ie_q[3] && dcd_chg)); // R9
endmodule

bind modem_irq_regs mi_checker u_mi_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_ack      (bus_ack),
  .dtr_out      (dtr_out),
  .rts_out      (rts_out),
  .tx_may_start (tx_may_start),
  .irq          (irq),
  .rx_avail     (rx_avail),
  .tx_empty     (tx_empty),
  .ie_q         (ie_q),
  .ctl_q        (ctl_q),
  .cts_s        (lines_s.cts),
  .dcd_edge     (dcd_edge),
  .dcd_chg      (dcd_chg),
  .isr_code     (isr_code)
);

// File: tb/modem_irq_regs_bench.sv
module modem_irq_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ack;
  logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
  logic       rx_avail = 1'b0, tx_empty = 1'b0;
  logic       dtr_out, rts_out, tx_may_start, irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modem_irq_regs u_modem_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in),
    .dcd_in(dcd_in), .rx_avail(rx_avail), .tx_empty(tx_empty),
    .dtr_out(dtr_out), .rts_out(rts_out), .tx_may_start(tx_may_start), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic wr, input logic [3:0] a, input logic [7:0] wd,
                          output logic [7:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    chk("R1 ack", {7'd0, bus_ack}, 8'h01);
    rd = bus_rdata;
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] wd);
    logic [7:0] unused;
    bus_xfer(1'b1, a, wd, unused);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] rd;
    bus_xfer(1'b0, a, 8'h00, rd);
    chk(tag, rd, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R5 dtr/rts reset", {6'd0, rts_out, dtr_out}, 8'h03);
    rd_chk("R11 ie reset", 4'd4, 8'h00);
    rd_chk("R11 ctl reset", 4'd7, 8'h00);
    rd_chk("R11 msr reset", 4'd2, 8'h00);
    rd_chk("R5 mc reset", 4'd6, 8'h03);
  endtask

  task automatic t_ack_single();
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 4'd4;
    @(negedge clk);
    chk("R1 ack rises", {7'd0, bus_ack}, 8'h01);
    bus_req = 1'b0;
    @(negedge clk);
    chk("R1 ack one cycle", {7'd0, bus_ack}, 8'h00);
  endtask

  task automatic t_levels();
    cts_in = 1'b1; ri_in = 1'b1;
    settle();
    rd_chk("R2 cts+ri", 4'd2, 8'h50);
    dsr_in = 1'b1;
    settle();
    rd_chk("R2 cts+dsr+ri", 4'd2, 8'h70);
    cts_in = 1'b0; dsr_in = 1'b0; ri_in = 1'b0;
    settle();
    rd_chk("R2 all low", 4'd2, 8'h00);
  endtask

  task automatic t_dcd_change();
    wr_reg(4'd4, 8'h08);
    dcd_in = 1'b1;
    settle();
    rd_chk("R3 rise sets flag", 4'd2, 8'h88);
    chk("R9 irq on carrier change", {7'd0, irq}, 8'h01);
    rd_chk("R7 modem code", 4'd3, 8'h8C);
    wr_reg(4'd2, 8'h5A);
    rd_chk("R3 write clears", 4'd2, 8'h80);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);
    rd_chk("R7 idle status", 4'd3, 8'h00);
    dcd_in = 1'b0;
    settle();
    rd_chk("R3 fall sets flag", 4'd2, 8'h08);
    wr_reg(4'd2, 8'h00);
    wr_reg(4'd4, 8'h00);
  endtask

  task automatic t_mask();
    wr_reg(4'd4, 8'hFF);
    rd_chk("R4 mask storage", 4'd4, 8'h0B);
    wr_reg(4'd4, 8'h00);
    rd_chk("R4 mask cleared", 4'd4, 8'h00);
  endtask

  task automatic t_modem_ctrl();
    wr_reg(4'd6, 8'hFE);
    rd_chk("R5 mc read", 4'd6, 8'h02);
    chk("R5 pins after FE", {6'd0, rts_out, dtr_out}, 8'h02);
    wr_reg(4'd6, 8'h01);
    chk("R5 pins after 01", {6'd0, rts_out, dtr_out}, 8'h01);
    wr_reg(4'd6, 8'h03);
  endtask

  task automatic t_flow();
    cts_in = 1'b0;
    settle();
    chk("R6 flow off", {7'd0, tx_may_start}, 8'h01);
    wr_reg(4'd7, 8'hFF);
    rd_chk("R6 ctl read", 4'd7, 8'h01);
    chk("R6 gated by cts low", {7'd0, tx_may_start}, 8'h00);
    cts_in = 1'b1;
    settle();
    chk("R6 cts high", {7'd0, tx_may_start}, 8'h01);
    cts_in = 1'b0;
    settle();
    chk("R6 cts low again", {7'd0, tx_may_start}, 8'h00);
    wr_reg(4'd7, 8'h00);
    chk("R6 flow disabled", {7'd0, tx_may_start}, 8'h01);
  endtask

  task automatic t_priority();
    rx_avail = 1'b1; tx_empty = 1'b1;
    @(negedge clk);
    chk("R8 masked sources ignored", {7'd0, irq}, 8'h00);
    rd_chk("R8 masked status", 4'd3, 8'h00);
    wr_reg(4'd4, 8'h0B);
    dcd_in = 1'b1;
    settle();
    rd_chk("R8 rx wins", 4'd3, 8'h84);
    rx_avail = 1'b0;
    @(negedge clk);
    chk("R9 irq tx", {7'd0, irq}, 8'h01);
    rd_chk("R8 tx next", 4'd3, 8'h88);
    tx_empty = 1'b0;
    rd_chk("R8 modem last", 4'd3, 8'h8C);
    wr_reg(4'd4, 8'h03);
    chk("R9 modem masked", {7'd0, irq}, 8'h00);
    rd_chk("R7 none pending", 4'd3, 8'h00);
    wr_reg(4'd2, 8'h00);
    dcd_in = 1'b0;
    settle();
    wr_reg(4'd2, 8'h00);
    wr_reg(4'd4, 8'h00);
  endtask

  task automatic t_reserved();
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 5 || a >= 8) wr_reg(4'(a), 8'hFF);
    end
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 5 || a >= 8) rd_chk("R10 reserved reads 0", 4'(a), 8'h00);
    end
    rd_chk("R10 mask untouched", 4'd4, 8'h00);
    rd_chk("R10 mc untouched", 4'd6, 8'h03);
    rd_chk("R10 ctl untouched", 4'd7, 8'h00);
    rd_chk("R10 msr untouched", 4'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ack_single();
    t_levels();
    t_dcd_change();
    t_mask();
    t_modem_ctrl();
    t_flow();
    t_priority();
    t_reserved();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule